// File: doc/BRIEF.md
# Eight-Bit Dual-Compare Timer

This block is an 8-bit up-counter. It advances on one selected count source: one of several single-cycle tick enables from a prescaler elsewhere on the chip, or the rising edge, falling edge or both edges of an external clock pin. The count is compared against two compare registers on every cycle. A match sets a flag and can drive one waveform output pin with a programmable action. A match can also clear the counter.

A wrap from 0xFF to 0x00 sets an overflow flag. Each of the three flags has its own interrupt enable, and the flags are ORed onto one interrupt line. The counter can also be cleared from an external reset pin. In trigger mode, any clear halts counting until a chosen edge appears on a trigger pin.

Software reaches the block through a plain register port with separate write and read strobes. Each register is selected by a 3-bit address:

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | [2:0] clock select, [4:3] clear select, [5] overflow interrupt enable, [6] match-A interrupt enable, [7] match-B interrupt enable |
| 1 | STAT | [0] overflow flag, [1] match-A flag, [2] match-B flag, [3] halted (read-only) |
| 2 | OUTSEL | [1:0] action on match A, [3:2] action on match B |
| 3 | TRIG | [0] trigger enable, [2:1] trigger edge select |
| 4 | CNT | counter value, readable and writable |
| 5 | CMPA | compare value A |
| 6 | CMPB | compare value B |

The block has no streaming data path, so every pin is a plain control or status signal and none of them uses a handshake.

Top module: `tmr8_dual`

## Requirements
- R1: The clock select field CTRL[2:0] picks the count source. 1, 2 and 3 pick tick_i[0], tick_i[1] and tick_i[2]. 4 picks rising edges of ext_clk_i, 5 picks falling edges, and 6 picks both edges. Each selected event adds one to the count, and events from sources that are not selected are ignored.
- R2: When the clock select is 0 or 7, no source is selected and the counter holds its value.
- R3: When counting takes the value from 0xFF to 0x00, STAT bit 0 (overflow) is set.
- R4: STAT bit 1 is set on a match with CMPA, and STAT bit 2 is set on a match with CMPB.
- R5: A match is taken in the last cycle in which the count equals the compare value, which is the cycle in which the counter advances away from that value. A count that sits at the compare value does not set the flag.
- R6: The clear select field CTRL[4:3] controls matches. With 01, a match A loads 0 into the counter instead of the next value. With 10, a match B does the same.
- R7: With clear select 11, a rising edge on ext_rst_i, after a two-flop synchronizer, clears the counter. With any other clear select, the pin has no effect.
- R8: With TRIG[0] set, any clear makes the counter 0 and halts counting, and STAT bit 3 reads 1 while halted. Counting resumes on the edge chosen by TRIG[2:1] on trig_i: 01 rising, 10 falling, 11 both, 00 none.
- R9: On a match, wave_o takes the 2-bit action for that match: 00 no change, 01 drive 0, 10 drive 1, 11 toggle.
- R10: When both matches occur in the same cycle, the action for match B is applied, unless that action is 00.
- R11: irq_o is high whenever any flag is set and its enable bit in CTRL[7:5] is 1.
- R12: A flag clears only when a 0 is written to its STAT bit after a STAT read has returned that bit as 1. A set event in the same cycle as the clearing write wins.
- R13: After reset, CTRL, STAT flags, OUTSEL, TRIG and CNT are 0, CMPA and CMPB are 0xFF, and wave_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (a STAT read arms flag clearing) |
| rd_data | output | 8 | Read data for the register at addr |
| tick_i | input | 3 | Prescaler tick enables, one cycle wide |
| ext_clk_i | input | 1 | External clock pin |
| ext_rst_i | input | 1 | External counter-clear pin |
| trig_i | input | 1 | Trigger pin that restarts a halted counter |
| wave_o | output | 1 | Waveform output driven by compare matches |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the external pins are slow compared with the system clock, so that every level survives the synchronizer, and that ticks are single-cycle pulses. The stimulus holds each pin level for at least three clock cycles and pulses ticks for one cycle, with an idle cycle between pulses. Register writes and count events happen in separate cycles, with one exception. That exception is the deliberate case in which a STAT clear and an overflow land in the same cycle, and it is there to exercise the set-wins rule.

// File: rtl/tmr8_pkg.sv
`timescale 1ns/1ps
package tmr8_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } out_act_e;

  typedef enum logic [1:0] {
    CLR_OFF = 2'b00,
    CLR_A   = 2'b01,
    CLR_B   = 2'b10,
    CLR_PIN = 2'b11
  } clr_sel_e;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_OUT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd5;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd6;
endpackage

// File: rtl/tmr8_pin_sync.sv
`timescale 1ns/1ps
module tmr8_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic lvl_d
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign lvl   = sh_q[STAGES-1];
  assign lvl_d = sh_q[STAGES];
endmodule

// File: rtl/tmr8_count_core.sv
`timescale 1ns/1ps
module tmr8_count_core import tmr8_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int NTICK = 3,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTICK-1:0] tick_i,
  input  logic             eclk_rise,
  input  logic             eclk_fall,
  input  logic             erst_rise,
  input  logic             trg_rise,
  input  logic             trg_fall,
  input  logic [SEL_W-1:0] clk_sel,
  input  clr_sel_e         clr_sel,
  input  logic             trig_en,
  input  logic [1:0]       trig_edge,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             match_a,
  output logic             match_b,
  output logic             wrap,
  output logic             run
);
  logic evt, adv, clr_evt, trg_hit;

  always_comb begin
    evt = 1'b0;
    for (int i = 0; i < NTICK; i++)
      if (clk_sel == SEL_W'(i + 1)) evt = tick_i[i];
    if (clk_sel == SEL_W'(NTICK + 1)) evt = eclk_rise;
    if (clk_sel == SEL_W'(NTICK + 2)) evt = eclk_fall;
    if (clk_sel == SEL_W'(NTICK + 3)) evt = eclk_rise | eclk_fall;
  end

  // a match belongs to the cycle in which the count leaves the compare value
  assign adv     = evt & run;
  assign match_a = adv & (cnt == cmpa);
  assign match_b = adv & (cnt == cmpb);
  assign wrap    = adv & (cnt == {CNT_W{1'b1}});

  assign clr_evt = ((clr_sel == CLR_A) & match_a) |
                   ((clr_sel == CLR_B) & match_b) |
                   ((clr_sel == CLR_PIN) & erst_rise);

  always_comb begin
    unique case (trig_edge)
      2'b01:   trg_hit = trg_rise;
      2'b10:   trg_hit = trg_fall;
      2'b11:   trg_hit = trg_rise | trg_fall;
      default: trg_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (wr_cnt)  cnt <= wr_val;
    else if (clr_evt) cnt <= '0;
    else if (adv)     cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= 1'b1;
    else if (!trig_en) run <= 1'b1;
    else if (clr_evt) run <= 1'b0;
    else if (trg_hit) run <= 1'b1;
  end
endmodule

// File: rtl/tmr8_out_ctl.sv
`timescale 1ns/1ps
module tmr8_out_ctl import tmr8_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     match_a,
  input  logic     match_b,
  input  out_act_e act_a,
  input  out_act_e act_b,
  output logic     wave
);
  function automatic logic apply_act(input out_act_e a, input logic cur);
    unique case (a)
      ACT_LOW:  apply_act = 1'b0;
      ACT_HIGH: apply_act = 1'b1;
      ACT_TOG:  apply_act = ~cur;
      default:  apply_act = cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             wave <= 1'b0;
    else if (match_b && act_b != ACT_NONE)  wave <= apply_act(act_b, wave);
    else if (match_a)                       wave <= apply_act(act_a, wave);
  end
endmodule

// File: rtl/tmr8_dual.sv
`timescale 1ns/1ps
module tmr8_dual import tmr8_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int NTICK = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic [NTICK-1:0]  tick_i,
  input  logic              ext_clk_i,
  input  logic              ext_rst_i,
  input  logic              trig_i,
  output logic              wave_o,
  output logic              irq_o
);
  localparam int SEL_W = $clog2(NTICK + 4);
  localparam int NPIN  = 3;

  logic [7:0]       ctrl_q;
  logic [3:0]       outsel_q;
  logic [2:0]       trig_q;
  logic [CNT_W-1:0] cmpa, cmpb, cnt;
  logic [2:0]       flags, armed;
  logic             match_a, match_b, wrap, run;

  logic [SEL_W-1:0] clk_sel;
  logic [1:0]       clr_sel, act_b;
  logic             trig_en, ovf_ie, wr_cnt;

  assign clk_sel = ctrl_q[SEL_W-1:0];
  assign clr_sel = ctrl_q[4:3];
  assign ovf_ie  = ctrl_q[5];
  assign trig_en = trig_q[0];
  assign act_b   = outsel_q[3:2];
  assign wr_cnt  = wr_en && (addr == A_CNT);

  // pin 0: external clock, pin 1: external clear, pin 2: trigger
  logic [NPIN-1:0] pins, lvl, lvl_d;
  assign pins = {trig_i, ext_rst_i, ext_clk_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    tmr8_pin_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pins[p]), .lvl(lvl[p]), .lvl_d(lvl_d[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      outsel_q <= '0;
      trig_q   <= '0;
      cmpa     <= '1;
      cmpb     <= '1;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl_q   <= wr_data;
        A_OUT:   outsel_q <= wr_data[3:0];
        A_TRIG:  trig_q   <= wr_data[2:0];
        A_CMPA:  cmpa     <= wr_data[CNT_W-1:0];
        A_CMPB:  cmpb     <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  tmr8_count_core #(.CNT_W(CNT_W), .NTICK(NTICK), .SEL_W(SEL_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .eclk_rise (lvl[0] & ~lvl_d[0]),
    .eclk_fall (~lvl[0] & lvl_d[0]),
    .erst_rise (lvl[1] & ~lvl_d[1]),
    .trg_rise  (lvl[2] & ~lvl_d[2]),
    .trg_fall  (~lvl[2] & lvl_d[2]),
    .clk_sel   (clk_sel),
    .clr_sel   (clr_sel_e'(clr_sel)),
    .trig_en   (trig_en),
    .trig_edge (trig_q[2:1]),
    .cmpa      (cmpa),
    .cmpb      (cmpb),
    .wr_cnt    (wr_cnt),
    .wr_val    (wr_data[CNT_W-1:0]),
    .cnt       (cnt),
    .match_a   (match_a),
    .match_b   (match_b),
    .wrap      (wrap),
    .run       (run)
  );

  tmr8_out_ctl u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .match_a (match_a),
    .match_b (match_b),
    .act_a   (out_act_e'(outsel_q[1:0])),
    .act_b   (out_act_e'(act_b)),
    .wave    (wave_o)
  );

  // flag bits: 0 overflow, 1 match A, 2 match B
  logic [2:0] flag_set, flag_clr;
  assign flag_set = {match_b, match_a, wrap};
  assign flag_clr = (wr_en && addr == A_STAT) ? (armed & ~wr_data[2:0]) : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= (flags & ~flag_clr) | flag_set;
      if (wr_en && addr == A_STAT)      armed <= '0;
      else if (rd_en && addr == A_STAT) armed <= armed | flags;
    end
  end

  assign irq_o = |(flags & ctrl_q[7:5]);

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = ctrl_q;
      A_STAT:  rd_data = {4'b0, ~run, flags};
      A_OUT:   rd_data = {4'b0, outsel_q};
      A_TRIG:  rd_data = {5'b0, trig_q};
      A_CNT:   rd_data = 8'(cnt);
      A_CMPA:  rd_data = 8'(cmpa);
      A_CMPB:  rd_data = 8'(cmpb);
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/tmr8_dual_chk.sv
`timescale 1ns/1ps
module tmr8_dual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] clk_sel,
  input logic [1:0] clr_sel,
  input logic [1:0] act_b,
  input logic [7:0] cnt,
  input logic       wrap,
  input logic       match_a,
  input logic       match_b,
  input logic       run,
  input logic [2:0] flags,
  input logic       ovf_ie,
  input logic       wave_o,
  input logic       irq_o
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_sel == 3'd0 || clk_sel == 3'd7) && !wr_en && clr_sel != 2'b11) |=> $stable(cnt));

  // R3
  wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[0]);

  // R4
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |=> flags[1]);

  // R10
  b_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && match_b && act_b == 2'b01) |=> !wave_o);

  // R8
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> (cnt == $past(cnt) || cnt == 8'h00));

  // R11
  irq_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && ovf_ie) |-> irq_o);
endmodule

bind tmr8_dual tmr8_dual_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clk_sel(clk_sel), .clr_sel(clr_sel),
  .act_b(act_b), .cnt(cnt), .wrap(wrap), .match_a(match_a), .match_b(match_b),
  .run(run), .flags(flags), .ovf_ie(ovf_ie), .wave_o(wave_o), .irq_o(irq_o)
);

// File: tb/tmr8_dual_tb.sv
`timescale 1ns/1ps
module tmr8_dual_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [2:0] tick_i = 3'b000;
  logic       ext_clk_i = 1'b0, ext_rst_i = 1'b0, trig_i = 1'b0;
  logic       wave_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  tmr8_dual u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .tick_i(tick_i), .ext_clk_i(ext_clk_i),
    .ext_rst_i(ext_rst_i), .trig_i(trig_i), .wave_o(wave_o), .irq_o(irq_o)
  );

  // monitor: pops one expectation per read strobe, mid-cycle
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s: read got %02h expected %02h", t, rd_data, e);
      end
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
  endtask

  task automatic chk_bit(input string t, input logic act, input logic e);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic tick(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 3'b000;
      tick_i[idx] = 1'b1;
      step();
      tick_i = 3'b000;
      step();
    end
  endtask

  task automatic pin_pulse(ref logic pin);
    pin = 1'b1; step(4);
    pin = 1'b0; step(4);
  endtask

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step();

    // R13 reset state
    rd_exp(3'd0, 8'h00, "R13 ctrl");
    rd_exp(3'd1, 8'h00, "R13 stat");
    rd_exp(3'd4, 8'h00, "R13 cnt");
    rd_exp(3'd5, 8'hFF, "R13 cmpa");
    rd_exp(3'd6, 8'hFF, "R13 cmpb");
    chk_bit("R13 wave", wave_o, 1'b0);
    chk_bit("R13 irq", irq_o, 1'b0);

    // R2 no source selected
    tick(0, 3);
    rd_exp(3'd4, 8'h00, "R2 hold sel0");

    // R1 tick sources
    wr(3'd0, 8'h01);
    tick(0, 5);
    tick(1, 2);
    rd_exp(3'd4, 8'h05, "R1 tick0 only");
    wr(3'd0, 8'h02);
    tick(1, 2);
    rd_exp(3'd4, 8'h07, "R1 tick1");
    wr(3'd4, 8'h00);

    // R4 R5 R9 match A drive 1
    wr(3'd5, 8'h03);
    wr(3'd2, 8'h02);
    tick(1, 3);
    step(3);
    rd_exp(3'd1, 8'h00, "R5 sitting at compare");
    chk_bit("R5 wave before leave", wave_o, 1'b0);
    tick(1, 1);
    rd_exp(3'd1, 8'h02, "R4 flag A");
    chk_bit("R9 drive1", wave_o, 1'b1);
    wr(3'd1, 8'h00);
    rd_exp(3'd1, 8'h00, "R12 read then clear");

    // R9 toggle
    wr(3'd2, 8'h03);
    wr(3'd4, 8'h02);
    tick(1, 2);
    chk_bit("R9 toggle", wave_o, 1'b0);

    // R6 clear on A then on B
    wr(3'd0, 8'h0A);
    wr(3'd4, 8'h00);
    tick(1, 4);
    rd_exp(3'd4, 8'h00, "R6 clear A");
    wr(3'd0, 8'h12);
    wr(3'd6, 8'h02);
    wr(3'd4, 8'h00);
    tick(1, 3);
    rd_exp(3'd4, 8'h00, "R6 clear B");
    rd_exp(3'd1, 8'h06, "R4 flags A B");
    wr(3'd1, 8'h00);

    // R10 priority
    wr(3'd0, 8'h02);
    wr(3'd5, 8'h05);
    wr(3'd6, 8'h05);
    wr(3'd2, 8'h06);
    wr(3'd4, 8'h05);
    tick(1, 1);
    chk_bit("R10 B drive0 wins", wave_o, 1'b0);
    wr(3'd2, 8'h09);
    wr(3'd4, 8'h05);
    tick(1, 1);
    chk_bit("R10 B drive1 wins", wave_o, 1'b1);

    // R3 R11 overflow
    wr(3'd0, 8'h22);
    chk_bit("R11 no enabled flag", irq_o, 1'b0);
    wr(3'd4, 8'hFE);
    tick(1, 2);
    chk_bit("R11 irq on ovf", irq_o, 1'b1);

    // R12 clear protocol
    wr(3'd1, 8'h00);
    rd_exp(3'd1, 8'h07, "R12 write before read ignored, R3 ovf");
    wr(3'd1, 8'h00);
    rd_exp(3'd1, 8'h00, "R12 cleared after read");
    chk_bit("R11 irq dropped", irq_o, 1'b0);

    // R12 set wins
    wr(3'd4, 8'hFF);
    tick(1, 1);
    rd_exp(3'd1, 8'h01, "R12 ovf again");
    wr(3'd4, 8'hFF);
    wr_en = 1'b1; addr = 3'd1; wr_data = 8'h00; tick_i = 3'b010;
    step();
    wr_en = 1'b0; tick_i = 3'b000;
    step();
    rd_exp(3'd1, 8'h01, "R12 set wins");
    wr(3'd1, 8'h00);
    rd_exp(3'd1, 8'h00, "R12 cleared");

    // R1 external clock
    wr(3'd0, 8'h06);
    wr(3'd4, 8'h00);
    pin_pulse(ext_clk_i);
    pin_pulse(ext_clk_i);
    rd_exp(3'd4, 8'h04, "R1 both edges");
    wr(3'd0, 8'h04);
    wr(3'd4, 8'h00);
    pin_pulse(ext_clk_i);
    pin_pulse(ext_clk_i);
    rd_exp(3'd4, 8'h02, "R1 rising edges");

    // R7 external clear
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h09);
    pin_pulse(ext_rst_i);
    rd_exp(3'd4, 8'h09, "R7 pin ignored without select");
    wr(3'd0, 8'h18);
    pin_pulse(ext_rst_i);
    rd_exp(3'd4, 8'h00, "R7 pin clear");

    // R8 trigger mode
    wr(3'd0, 8'h1A);
    wr(3'd3, 8'h03);
    wr(3'd4, 8'h07);
    pin_pulse(ext_rst_i);
    rd_exp(3'd1, 8'h08, "R8 halted flag");
    tick(1, 3);
    rd_exp(3'd4, 8'h00, "R8 halted count");
    trig_i = 1'b1;
    step(4);
    tick(1, 2);
    rd_exp(3'd4, 8'h02, "R8 resumed");
    rd_exp(3'd1, 8'h00, "R8 running");

    step(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule